// File: doc/BRIEF.md
# Serial Input Edge Event Detector

This block sits behind a serial input expander. Every time the serial engine finishes a frame, it presents the freshly captured input bits together with a one-cycle completion strobe. The detector compares each bit with the value the same pin had in the previous completed frame. According to a two-bit selection per pin, it flags a rising edge, a falling edge, either edge, or nothing.

Each flagged change sets a sticky status bit. Status bits are grouped eight to a bank, and software clears them by writing ones. One interrupt line is high whenever any status bit is set. A small register port gives software one 16-bit edge-selection register per bank and one status byte per bank. The block does not shift serial data itself. It only sees the parallel result once per frame.

While the interface is disabled, frames are ignored. After the interface is enabled, the first completed frame only records the baseline pin values and cannot report a change.

Top module: `sio_edge_event`

## Requirements
- R1: After reset every edge-selection register reads 0, every status byte reads 0 and `event_irq` is low.
- R2: The edge-selection register of bank b sits at address 0x10 + 2·b and reads back the 16-bit value written. Pin n of the bank is controlled by bits [2n+1:2n]. Writes to the odd addresses 0x11..0x1F change nothing.
- R3: Selection encoding: 00 means no detection, 01 means a 0→1 change, 10 means a 1→0 change, 11 means a change in either direction.
- R4: A change is evaluated only in a cycle where `frame_done` is high. The new bit is compared with the bit captured at the previous accepted frame. Changes on `frame_bits` without a strobe raise nothing.
- R5: Frames that arrive while `link_en` is low are ignored. The first frame accepted after `link_en` rises (or after reset) only records the baseline and raises no event.
- R6: The status byte of bank i sits at address 0x20 + i. Its bit j reports input pin 8·i + j (`frame_bits[8i+j]`). A set bit stays set until software clears it.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged, and writing 0xFF clears the whole bank.
- R8: `event_irq` is high in the cycle after any status bit becomes set. It falls only once every set bit has been cleared.
- R9: When a detection and a clear hit the same status bit in the same cycle, the bit ends set.
- R10: Writing 00 to a pin's selection does not clear a status bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Serial interface enabled |
| frame_done | input | 1 | One-cycle strobe: a frame has completed |
| frame_bits | input | 64 | Input pin values captured from the completed frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (write and read) |
| reg_wdata | input | 16 | Register write data (status writes use bits [7:0]) |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| event_irq | output | 1 | High while any status bit is set |

## Verification
A frame strobe that produces a detection can land in the same cycle as a write-one-to-clear to the same status byte. The result must be the detection kept plus the other written bits removed. The bench provokes this with a directed case: a clear of a bit that the same strobe re-detects, next to another bit that is cleared outright. Random cycles also mix strobes and status writes freely. Each status byte and the interrupt are then compared against a bench model that applies clear-then-set.

// File: rtl/sio_evt_pkg.sv
package sio_evt_pkg;
  // per-pin edge selection codes
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int CFG_BASE  = 16;  // 0x10, two addresses per bank
  localparam int STAT_BASE = 32;  // 0x20, one address per bank
endpackage

// File: rtl/sio_evt_cfg.sv
module sio_evt_cfg
  import sio_evt_pkg::*;
#(
  parameter int NB  = 8,
  parameter int PPB = 8,
  parameter int AW  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [2*PPB-1:0]      wr_data,
  output logic [NB*2*PPB-1:0]   cfg_flat
);
  localparam int CW = 2 * PPB;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] MY_ADDR = AW'(CFG_BASE + 2 * b);
    logic          sel;
    logic [CW-1:0] cfg_q, cfg_d;

    assign sel = wr_en && (wr_addr == MY_ADDR);

    always_comb begin
      cfg_d = cfg_q;
      if (sel) cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q <= '0;
      else if (sel) cfg_q <= cfg_d;
    end

    assign cfg_flat[b*CW +: CW] = cfg_q;
  end
endmodule

// File: rtl/sio_evt_detect.sv
module sio_evt_detect
  import sio_evt_pkg::*;
#(
  parameter int NPIN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              frame_done,
  input  logic [NPIN-1:0]   frame_bits,
  input  logic [2*NPIN-1:0] cfg_flat,
  output logic [NPIN-1:0]   hit,
  output logic              primed
);
  logic [NPIN-1:0] prev_q, prev_d;
  logic            primed_q, primed_d;
  logic            accept;

  assign accept = link_en && frame_done;

  always_comb begin
    prev_d   = prev_q;
    primed_d = primed_q;
    if (!link_en) begin
      primed_d = 1'b0;
    end else if (frame_done) begin
      prev_d   = frame_bits;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (accept) prev_q <= prev_d;
      primed_q <= primed_d;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    edge_sel_e sel;
    logic      rise, fall;
    assign sel  = edge_sel_e'(cfg_flat[2*p +: 2]);
    assign rise = !prev_q[p] &&  frame_bits[p];
    assign fall =  prev_q[p] && !frame_bits[p];
    always_comb begin
      hit[p] = 1'b0;
      if (accept && primed_q) begin
        unique case (sel)
          EDGE_RISE: hit[p] = rise;
          EDGE_FALL: hit[p] = fall;
          EDGE_ANY:  hit[p] = rise || fall;
          default:   hit[p] = 1'b0;
        endcase
      end
    end
  end

  assign primed = primed_q;
endmodule

// File: rtl/sio_evt_status.sv
module sio_evt_status
  import sio_evt_pkg::*;
#(
  parameter int NB  = 8,
  parameter int PPB = 8,
  parameter int AW  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [PPB-1:0]     wr_data,
  input  logic [NB*PPB-1:0]  hit,
  output logic [NB*PPB-1:0]  stat,
  output logic [NB*PPB-1:0]  clr,
  output logic               irq
);
  localparam int NPIN = NB * PPB;

  logic [NPIN-1:0] stat_q, stat_d;
  logic            irq_q, irq_d;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] MY_ADDR = AW'(STAT_BASE + b);
    assign clr[b*PPB +: PPB] =
      (wr_en && (wr_addr == MY_ADDR)) ? wr_data : '0;
  end

  // detection is applied after the clear, so it wins
  always_comb begin
    stat_d = (stat_q & ~clr) | hit;
    irq_d  = |stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;
endmodule

// File: rtl/sio_edge_event.sv
module sio_edge_event
  import sio_evt_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int PINS_PER_BANK = 8,
  parameter int ADDR_W        = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  link_en,
  input  logic                                  frame_done,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0]    frame_bits,
  input  logic                                  reg_wr,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [2*PINS_PER_BANK-1:0]            reg_wdata,
  output logic [2*PINS_PER_BANK-1:0]            reg_rdata,
  output logic                                  event_irq
);
  localparam int NPIN = NUM_BANKS * PINS_PER_BANK;
  localparam int DW   = 2 * PINS_PER_BANK;

  logic [2*NPIN-1:0] cfg_flat;
  logic [NPIN-1:0]   det_hit;
  logic              det_primed;
  logic [NPIN-1:0]   stat_vec;
  logic [NPIN-1:0]   stat_clr;

  sio_evt_cfg #(.NB(NUM_BANKS), .PPB(PINS_PER_BANK), .AW(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .cfg_flat (cfg_flat)
  );

  sio_evt_detect #(.NPIN(NPIN)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .frame_done (frame_done),
    .frame_bits (frame_bits),
    .cfg_flat   (cfg_flat),
    .hit        (det_hit),
    .primed     (det_primed)
  );

  sio_evt_status #(.NB(NUM_BANKS), .PPB(PINS_PER_BANK), .AW(ADDR_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata[PINS_PER_BANK-1:0]),
    .hit     (det_hit),
    .stat    (stat_vec),
    .clr     (stat_clr),
    .irq     (event_irq)
  );

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(CFG_BASE + 2 * b))
        reg_rdata = cfg_flat[b*DW +: DW];
      if (reg_addr == ADDR_W'(STAT_BASE + b))
        reg_rdata = DW'(stat_vec[b*PINS_PER_BANK +: PINS_PER_BANK]);
    end
  end
endmodule

// File: rtl/sio_evt_chk.sv
module sio_evt_chk #(
  parameter int NB  = 8,
  parameter int PPB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              primed,
  input logic [NB*PPB-1:0] hit,
  input logic [NB*PPB-1:0] clr,
  input logic [NB*PPB-1:0] stat,
  input logic              irq
);
  // R4
  no_strobe_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> (hit == '0));

  // R5
  unprimed_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (hit == '0));

  // R9
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

  // R7
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hit) != '0) |=> ((stat & $past(clr & ~hit)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~clr) != '0) |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  // R8
  irq_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat != '0));
endmodule

bind sio_edge_event sio_evt_chk #(.NB(NUM_BANKS), .PPB(PINS_PER_BANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_done (frame_done),
  .primed     (det_primed),
  .hit        (det_hit),
  .clr        (stat_clr),
  .stat       (stat_vec),
  .irq        (event_irq)
);

// File: tb/sim_sio_edge_event.sv
module sim_sio_edge_event;
  logic        clk, rst_n, link_en, frame_done, reg_wr, event_irq;
  logic [63:0] frame_bits;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] m_cfg [8];
  logic [7:0]  m_stat[8];
  logic [63:0] m_prev;
  bit          m_primed;

  sio_edge_event u0 (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [63:0] exp_hits(logic [63:0] prev, logic [63:0] nb);
    logic [63:0] h = '0;
    for (int p = 0; p < 64; p++) begin
      logic [1:0] c = m_cfg[p/8][2*(p%8) +: 2];
      h[p] = (c[0] && !prev[p] && nb[p]) || (c[1] && prev[p] && !nb[p]);
    end
    return h;
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int b = 0; b < 8; b++) r |= (m_stat[b] != 0);
    return r;
  endfunction

  task automatic model_step(bit fd, logic [63:0] bits, bit wr, logic [5:0] a, logic [15:0] d);
    logic [63:0] h = '0;
    if (!link_en) m_primed = 0;
    else if (fd) begin
      if (m_primed) h = exp_hits(m_prev, bits);
      m_prev = bits; m_primed = 1;
    end
    for (int b = 0; b < 8; b++) begin
      logic [7:0] c = (wr && a == 6'(32 + b)) ? d[7:0] : 8'h00;
      m_stat[b] = (m_stat[b] & ~c) | h[8*b +: 8];
    end
    if (wr && a >= 6'h10 && a <= 6'h1F && !a[0]) m_cfg[(a - 6'h10) / 2] = d;
  endtask

  task automatic cycle(bit fd, logic [63:0] bits, bit wr, logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    frame_done = fd; frame_bits = bits; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(fd, bits, wr, a, d);
    #1;
    frame_done = 0; reg_wr = 0;
  endtask

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_stat(int b, string tag);
    reg_addr = 6'(32 + b); #1;
    chk(tag, reg_rdata, {8'h00, m_stat[b]});
  endtask

  task automatic check_all(string tag);
    for (int b = 0; b < 8; b++) check_stat(b, tag);
    chk({tag, " irq"}, {15'd0, event_irq}, {15'd0, exp_irq()});
  endtask

  task automatic clear_all();
    for (int b = 0; b < 8; b++) cycle(0, frame_bits, 1, 6'(32 + b), 16'h00FF);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; link_en = 0; frame_done = 0; frame_bits = '0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    for (int b = 0; b < 8; b++) begin m_cfg[b] = '0; m_stat[b] = '0; end
    m_prev = '0; m_primed = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int b = 0; b < 8; b++) begin
      reg_addr = 6'(16 + 2*b); #1; chk("R1 cfg", reg_rdata, 16'h0);
    end
    check_all("R1");

    // R2 readback and odd address
    cycle(0, '0, 1, 6'h16, 16'hA5C3);
    reg_addr = 6'h16; #1; chk("R2 readback", reg_rdata, 16'hA5C3);
    cycle(0, '0, 1, 6'h13, 16'hFFFF);
    reg_addr = 6'h12; #1; chk("R2 odd ignored", reg_rdata, 16'h0000);
    cycle(0, '0, 1, 6'h16, 16'h0000);

    // R5 priming: first accepted frame gives no event
    cycle(0, '0, 1, 6'h10, 16'hFFFF);
    link_en = 1;
    cycle(1, 64'hFF, 0, 0, 0);
    check_stat(0, "R5 prime");
    chk("R5 prime irq", {15'd0, event_irq}, 16'h0);
    cycle(1, 64'h00, 0, 0, 0);
    chk("R3 any-edge falls", {8'h0, m_stat[0]}, 16'h00FF);
    check_all("R3 any");
    clear_all();

    // R3 encodings on bank 1: pin0 rise, pin1 fall, pin2 any, pin3 none
    cycle(0, '0, 1, 6'h12, 16'h0039);
    cycle(1, 64'h0F00, 0, 0, 0);
    reg_addr = 6'h21; #1; chk("R3 rising set", reg_rdata, 16'h0005);
    cycle(1, 64'h0000, 0, 0, 0);
    reg_addr = 6'h21; #1; chk("R3 falling set", reg_rdata, 16'h0007);
    check_all("R3");

    // R7 write zero no effect, write one clears
    cycle(0, '0, 1, 6'h21, 16'h0000);
    check_stat(1, "R7 zero write");
    cycle(0, '0, 1, 6'h21, 16'h0001);
    reg_addr = 6'h21; #1; chk("R7 clear bit", reg_rdata, 16'h0006);

    // R10 disabling selection keeps status
    cycle(0, '0, 1, 6'h12, 16'h0000);
    reg_addr = 6'h21; #1; chk("R10 kept", reg_rdata, 16'h0006);
    // R8 irq stays until last bit cleared
    cycle(0, '0, 1, 6'h21, 16'h0002);
    chk("R8 irq held", {15'd0, event_irq}, 16'h1);
    cycle(0, '0, 1, 6'h21, 16'h0004);
    chk("R8 irq drop", {15'd0, event_irq}, 16'h0);

    // R4 bits change without strobe
    cycle(0, '0, 1, 6'h10, 16'hFFFF);
    cycle(0, 64'hFF, 0, 0, 0);
    cycle(0, 64'h00, 0, 0, 0);
    check_all("R4 no strobe");

    // R6 mapping: bank 5 pin 3 rising -> frame bit 43
    cycle(0, '0, 1, 6'h1A, 16'h0040);
    cycle(1, 64'd1 << 43, 0, 0, 0);
    reg_addr = 6'h25; #1; chk("R6 pin 43", reg_rdata, 16'h0008);

    // R9 collision: bank 0 all-edge; clear bits 0 and 1 while bit 0 toggles
    cycle(1, 64'h0, 0, 0, 0);
    cycle(1, 64'h3, 0, 0, 0);
    cycle(1, 64'h2, 1, 6'h20, 16'h0003);
    reg_addr = 6'h20; #1; chk("R9 detect wins", reg_rdata, 16'h0001);
    check_all("R9");
    clear_all();

    // R5 disabled frames ignored and re-priming after enable
    link_en = 0;
    cycle(1, 64'hFF, 0, 0, 0);
    check_all("R5 disabled");
    link_en = 1;
    cycle(1, 64'h00, 0, 0, 0);
    check_all("R5 reprime");
    cycle(1, 64'h01, 0, 0, 0);
    reg_addr = 6'h20; #1; chk("R5 after prime", reg_rdata, 16'h0001);

    // random mix, including R9-style collisions
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      logic [63:0] nb = {$urandom, $urandom};
      if (k == 0) link_en = ($urandom_range(0, 7) != 0);
      if (k <= 2)
        cycle(0, frame_bits, 1, 6'(16 + 2*$urandom_range(0, 7)), 16'($urandom));
      else if (k <= 5)
        cycle(1, nb, 0, 0, 0);
      else if (k <= 7)
        cycle(1, nb, 1, 6'(32 + $urandom_range(0, 7)), 16'($urandom));
      else
        cycle(0, frame_bits, 1, 6'(32 + $urandom_range(0, 7)), 16'($urandom));
      check_stat($urandom_range(0, 7), "R6 R7 R9 random");
      chk("R8 random irq", {15'd0, event_irq}, {15'd0, exp_irq()});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule